// File: doc/BRIEF.md
# DMA Channel Grant Arbiter

This block decides which of several DMA channels may drive a shared transfer engine. Each channel presents a request line, an enable bit, a request mask bit and a priority-group bit. It also supplies a 4-bit burst exponent. A channel is eligible when its request is high, its enable is set and its mask is clear. A one-cycle arbitration step then picks one eligible channel. Any eligible channel in the high group beats the whole default group. Inside a group, the lowest channel index wins. The result is a registered one-hot grant with a grant-valid flag.

Once granted, a channel keeps the engine for a burst. The engine reports each finished transfer on `xfer_done`. The block counts these pulses against the limit 2^R. R is the winner's exponent, captured at grant time and clamped to 10. The grant ends on whichever comes first: the burst count is reached, or a transfer arrives with `cycle_last` set because the channel's cycle has run out. After the grant ends, the block spends one clock arbitrating again.

The controller has two states. ARBITRATE is entered from reset; it stays there while nothing is eligible and moves to HOLD (transition *grant*) when some channel is eligible. HOLD stays there while the burst is in progress and returns to ARBITRATE (transition *yield*) on the final counted transfer or on a cycle-end transfer.

Top module: `dma_grant_arbiter`

## Requirements
- R1: When reset is asserted, `gnt` is all zero, `gnt_valid` is 0 and the burst counter is zero. While reset is held, these values do not change.
- R2: A channel is granted only if its `ch_req` bit is 1, its `ch_en` bit is 1 and its `ch_mask` bit is 0. When no channel meets this, `gnt_valid` stays 0.
- R3: If any eligible channel has its `ch_hi` bit set to 1, the grant goes to a channel in that high group, whatever lower-indexed default-group channels request.
- R4: Among eligible channels of the winning group, the one with the lowest index (bit 0 is channel 0) is granted.
- R5: In the ARBITRATE state, an eligible request present before a rising edge produces `gnt_valid`=1 and the one-hot `gnt` right after that edge. Before that edge, `gnt_valid` is 0.
- R6: While `gnt_valid` is 1, `gnt` has exactly one bit set and does not change, even when requests, priorities or exponents change. While `gnt_valid` is 0, `gnt` is zero.
- R7: The exponent field is `ch_exp[4*i+3:4*i]` for channel i. The winner's field is captured at grant time. `gnt_valid` falls right after the edge that samples the 2^R-th `xfer_done` pulse. Idle cycles between pulses are not counted.
- R8: An exponent field above 10 gives a burst of 1024 transfers, the same as 10.
- R9: An `xfer_done` pulse with `cycle_last`=1 during a grant ends it right after that edge, even when fewer than 2^R transfers have been counted.
- R10: `xfer_done` and `cycle_last` pulses while no grant is valid have no effect. The next burst still lasts its full 2^R transfers.
- R11: After a grant ends, at least one clock passes with `gnt_valid`=0. This clock is the arbitration step for the next winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | NUM_CH | Per-channel transfer request |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_mask | input | NUM_CH | Per-channel request mask (1 blocks the request) |
| ch_hi | input | NUM_CH | Per-channel priority group (1 = high group) |
| ch_exp | input | NUM_CH*EXP_W | Per-channel burst exponent, channel i at bits [EXP_W*i +: EXP_W] |
| xfer_done | input | 1 | One-cycle pulse from the engine per finished transfer |
| cycle_last | input | 1 | Qualifies `xfer_done`: the transfer ends the channel's cycle |
| gnt | output | NUM_CH | One-hot grant to the winning channel |
| gnt_valid | output | 1 | Grant is valid |

## Verification
Some rules are checked on every cycle:
- the grant is one-hot and stable while valid;
- a new grant always lands on a channel that was eligible one cycle earlier;
- a new grant goes to the high group whenever that group had an eligible channel;
- an eligible request in ARBITRATE always yields a grant on the next edge;
- a cycle-end transfer always ends the grant;
- the burst counter stays within its captured limit, and is zero whenever no grant is held.

Other behaviour can only be shown by the bench's scenarios:
- the exact lowest-index choice among several requesters;
- the exact burst length for a given exponent, including the clamp of large exponents to 1024 transfers;
- that the exponent is captured at grant time;
- that transfer pulses while idle are ignored.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // Controller states: pick a winner, or hold the engine for a burst.
    typedef enum logic [0:0] {
        ST_ARBITRATE = 1'b0,
        ST_HOLD      = 1'b1
    } arb_state_e;

endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] elig,
    input  logic [NUM_CH-1:0] hi,
    output logic [NUM_CH-1:0] win,
    output logic              any
);
    logic [NUM_CH-1:0] hi_elig;
    logic [NUM_CH-1:0] pool;
    logic [NUM_CH:0]   seen;

    // The high group masks out the default group whenever it has a candidate.
    assign hi_elig = elig & hi;
    assign pool    = (|hi_elig) ? hi_elig : elig;
    assign any     = |elig;
    assign seen[0] = 1'b0;

    // Fixed order: a lower index shadows every higher one.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_prio
        assign win[i]    = pool[i] & ~seen[i];
        assign seen[i+1] = seen[i] | pool[i];
    end

endmodule

// File: rtl/dma_arb_burst_ctr.sv
module dma_arb_burst_ctr #(
    parameter int EXP_W   = 4,
    parameter int MAX_EXP = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [EXP_W-1:0] exp_in,
    input  logic             held,
    input  logic             xfer_done,
    input  logic             clear,
    output logic             burst_end
);
    localparam int               CNT_W     = MAX_EXP + 1;
    localparam logic [EXP_W-1:0] MAX_EXP_V = EXP_W'(MAX_EXP);

    logic [EXP_W-1:0] exp_c;
    logic [CNT_W-1:0] lim_load;
    logic [CNT_W-1:0] lim_m1;
    logic [CNT_W-1:0] cnt;
    logic             tick;

    assign exp_c     = (exp_in > MAX_EXP_V) ? MAX_EXP_V : exp_in;
    assign lim_load  = ~({CNT_W{1'b1}} << exp_c);
    assign tick      = held & xfer_done;
    assign burst_end = tick & (cnt == lim_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            lim_m1 <= '0;
        end else if (load) begin
            cnt    <= '0;
            lim_m1 <= lim_load;
        end else if (clear || burst_end) begin
            cnt    <= '0;
        end else if (tick) begin
            cnt    <= cnt + CNT_W'(1);
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim_m1); // R7

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !held |-> (cnt == '0)); // R10

endmodule

// File: rtl/dma_grant_arbiter.sv
module dma_grant_arbiter #(
    parameter int NUM_CH  = 8,
    parameter int EXP_W   = 4,
    parameter int MAX_EXP = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       ch_req,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH-1:0]       ch_mask,
    input  logic [NUM_CH-1:0]       ch_hi,
    input  logic [NUM_CH*EXP_W-1:0] ch_exp,
    input  logic                    xfer_done,
    input  logic                    cycle_last,
    output logic [NUM_CH-1:0]       gnt,
    output logic                    gnt_valid
);
    import dma_arb_pkg::*;

    arb_state_e        state, state_nxt;
    logic [NUM_CH-1:0] eligible;
    logic [NUM_CH-1:0] win;
    logic              any_elig;
    logic [EXP_W-1:0]  exp_sel;
    logic              held;
    logic              load;
    logic              burst_end;
    logic              rel_now;

    assign eligible = ch_req & ch_en & ~ch_mask;
    assign held     = (state == ST_HOLD);
    assign load     = (state == ST_ARBITRATE) && any_elig;
    assign rel_now  = held && xfer_done && (cycle_last || burst_end);

    dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
        .elig (eligible),
        .hi   (ch_hi),
        .win  (win),
        .any  (any_elig)
    );

    // Route the winner's exponent field to the burst counter.
    always_comb begin
        exp_sel = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (win[i]) exp_sel = exp_sel | ch_exp[i*EXP_W +: EXP_W];
        end
    end

    dma_arb_burst_ctr #(.EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .exp_in    (exp_sel),
        .held      (held),
        .xfer_done (xfer_done),
        .clear     (rel_now),
        .burst_end (burst_end)
    );

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ARBITRATE: if (any_elig) state_nxt = ST_HOLD;      // grant
            ST_HOLD:      if (rel_now)  state_nxt = ST_ARBITRATE; // yield
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ARBITRATE;
        else        state <= state_nxt;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt       <= '0;
            gnt_valid <= 1'b0;
        end else if (load) begin
            gnt       <= win;
            gnt_valid <= 1'b1;
        end else if (rel_now) begin
            gnt       <= '0;
            gnt_valid <= 1'b0;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ($countones(gnt) == 1)); // R6

    AST_GNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> (gnt == '0)); // R6

    AST_GNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && $past(gnt_valid)) |-> $stable(gnt)); // R6

    AST_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> ((gnt & $past(eligible)) != '0)); // R2

    AST_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gnt_valid) && ($past(eligible & ch_hi) != '0))
            |-> ((gnt & $past(ch_hi)) != '0)); // R3

    AST_ARB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && (eligible != '0)) |=> gnt_valid); // R5

    AST_CYCLE_END_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && xfer_done && cycle_last) |=> !gnt_valid); // R9

endmodule

// File: tb/dma_grant_arbiter_tb.sv
module dma_grant_arbiter_tb;
    localparam int NUM_CH = 8;
    localparam int EXP_W  = 4;
    localparam int NVEC   = 10;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NUM_CH-1:0]       ch_req = '0, ch_en = '0, ch_mask = '0, ch_hi = '0;
    logic [NUM_CH*EXP_W-1:0] ch_exp = '0;
    logic                    xfer_done = 1'b0, cycle_last = 1'b0;
    logic [NUM_CH-1:0]       gnt;
    logic                    gnt_valid;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_grant_arbiter #(.NUM_CH(NUM_CH), .EXP_W(EXP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_en(ch_en),
        .ch_mask(ch_mask), .ch_hi(ch_hi), .ch_exp(ch_exp),
        .xfer_done(xfer_done), .cycle_last(cycle_last),
        .gnt(gnt), .gnt_valid(gnt_valid)
    );

    // {req, en, mask, hi, expected gnt}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'b0000_0001, 8'hff,        8'h00,        8'h00,        8'b0000_0001},
        {8'b1010_0100, 8'hff,        8'h00,        8'h00,        8'b0000_0100},
        {8'b1010_0100, 8'hff,        8'h00,        8'b1000_0000, 8'b1000_0000},
        {8'b1010_0100, 8'hff,        8'h00,        8'b1010_0000, 8'b0010_0000},
        {8'b0000_0110, 8'b1111_1101, 8'h00,        8'h00,        8'b0000_0100},
        {8'b0000_0110, 8'hff,        8'b0000_0100, 8'h00,        8'b0000_0010},
        {8'b0000_0110, 8'b1111_1011, 8'b0000_0010, 8'h00,        8'b0000_0000},
        {8'hff,        8'hff,        8'h00,        8'b0100_0000, 8'b0100_0000},
        {8'b1100_0000, 8'hff,        8'h00,        8'b0000_0011, 8'b0100_0000},
        {8'b0000_0000, 8'hff,        8'h00,        8'hff,        8'b0000_0000}
    };

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // One transfer pulse, starting and ending at a falling edge.
    task automatic xfer(input bit last);
        xfer_done  = 1'b1;
        cycle_last = last;
        @(negedge clk);
        xfer_done  = 1'b0;
        cycle_last = 1'b0;
    endtask

    task automatic arm(input int ch, input logic [EXP_W-1:0] e);
        ch_exp = '0;
        ch_exp[ch*EXP_W +: EXP_W] = e;
        ch_req = NUM_CH'(1) << ch; ch_en = '1; ch_mask = '0; ch_hi = '0;
        @(negedge clk);
        check(gnt_valid && gnt == (NUM_CH'(1) << ch), "R5 grant on arm",
              32'(gnt), 32'(NUM_CH'(1) << ch));
        ch_req = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(gnt == '0 && !gnt_valid, "R1 reset outputs", 32'(gnt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!gnt_valid, "R1 idle after reset", 32'(gnt_valid), 0);

        // R2 R3 R4 R5: table walk
        for (int v = 0; v < NVEC; v++) begin
            {ch_req, ch_en, ch_mask, ch_hi} = VEC[v][39:8];
            ch_exp = '0;
            #1;
            check(!gnt_valid, $sformatf("R5 no grant before edge vec %0d", v),
                  32'(gnt_valid), 0);
            @(negedge clk);
            check(gnt == VEC[v][7:0] && gnt_valid == (VEC[v][7:0] != '0),
                  $sformatf("R2 R3 R4 vec %0d", v), 32'(gnt), 32'(VEC[v][7:0]));
            ch_req = '0;
            if (VEC[v][7:0] != '0) xfer(1'b1);
            check(!gnt_valid, $sformatf("R9 release vec %0d", v), 32'(gnt_valid), 0);
        end

        // R7 R6 R11: 8-transfer burst, exponent changed and rival raised mid-burst
        arm(2, 4'd3);
        ch_exp = '0;
        ch_req = 8'b0000_0001; ch_hi = 8'b0000_0001;
        for (int i = 0; i < 7; i++) begin
            xfer(1'b0);
            if (i % 2 == 1) @(negedge clk);
            check(gnt_valid && gnt == 8'b0000_0100, "R6 R7 hold during burst",
                  32'(gnt), 32'h04);
        end
        xfer(1'b0);
        check(!gnt_valid, "R7 release after 8", 32'(gnt_valid), 0);
        check(gnt == '0, "R11 idle step gnt zero", 32'(gnt), 0);
        @(negedge clk);
        check(gnt_valid && gnt == 8'b0000_0001, "R11 rearbitrated winner",
              32'(gnt), 32'h01);
        ch_req = '0; ch_hi = '0;
        xfer(1'b1);

        // R8: exponent 15 clamps to 1024
        arm(3, 4'd15);
        for (int i = 0; i < 1023; i++) xfer(1'b0);
        check(gnt_valid, "R8 still held after 1023", 32'(gnt_valid), 1);
        xfer(1'b0);
        check(!gnt_valid, "R8 release after 1024", 32'(gnt_valid), 0);

        // R9: cycle end before the burst limit
        arm(1, 4'd4);
        for (int i = 0; i < 3; i++) xfer(1'b0);
        check(gnt_valid, "R9 held before cycle end", 32'(gnt_valid), 1);
        xfer(1'b1);
        check(!gnt_valid, "R9 early release", 32'(gnt_valid), 0);

        // R10: transfer pulses while idle are ignored
        for (int i = 0; i < 5; i++) xfer(i == 4);
        check(!gnt_valid && gnt == '0, "R10 idle pulses no grant", 32'(gnt), 0);
        arm(5, 4'd2);
        for (int i = 0; i < 3; i++) xfer(1'b0);
        check(gnt_valid, "R10 full burst kept", 32'(gnt_valid), 1);
        xfer(1'b0);
        check(!gnt_valid, "R10 release after 4", 32'(gnt_valid), 0);

        // R1: reset during a grant
        arm(6, 4'd5);
        rst_n = 1'b0;
        @(negedge clk);
        check(!gnt_valid && gnt == '0, "R1 reset mid-burst", 32'(gnt), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule